// File: doc/BRIEF.md
# Serial Receive Character Buffer

This block sits between the receive shift stage of an asynchronous serial receiver and the register read path. Each finished character arrives with its eight data bits, a ninth data bit, the value of its first stop bit, a parity-check result and a LIN identifier tag. The character waits in a one-entry hold stage and then moves into a two-entry FIFO. Frame and parity status are stored with each character, so the status a reader sees always belongs to the character at the head of the FIFO.

The head entry is presented on two byte-wide read ports: a data byte and a status byte. The status byte also carries a receive-complete flag and a sticky overflow flag. Software reads the two bytes as a pair, and the FIFO advances on the second read of the pair. In normal mode software reads the status byte first and the data byte second. In the 9-bit low-byte-first mode the order is reversed. A LIN auto mode replaces the ninth bit with an identifier/response tag. An SPI-master mode forces the error flags to zero.

Top module: `rx_char_buffer`

## Requirements
- R1: The FIFO holds up to two characters and releases them in arrival order. A character strobed on `in_valid` at clock edge N is captured in the hold stage at that edge. If the FIFO has room, it enters the FIFO at edge N+1 and is visible on the read ports after that edge.
- R2: Status byte layout: bit 7 receive complete, bit 6 overflow, bit 2 frame error, bit 1 parity error, bit 0 ninth data bit. Bits 5 to 3 always read 0. The byte is 0x00 after reset.
- R3: Bit 7 of the status byte is 1 while the FIFO holds at least one unread character, and 0 when it is empty.
- R4: While `rx_enable` is low, the FIFO, the hold stage and the overflow flag are cleared, and `in_valid` is ignored.
- R5: Overflow is detected only when three conditions hold in the same cycle with no pop: the FIFO is full, a character waits in the hold stage, and `start_det` is high. The waiting character is then discarded, and status bit 6 reads 1 from the next cycle. Bit 6 returns to 0 after a data-byte read (`rd_lo`). A new overflow in the same cycle takes priority over that clear.
- R6: Status bit 2 is the inverse of the head character's first stop bit (1 when that stop bit was 0).
- R7: Status bit 1 is the head character's parity result when `parity_en` is 1, and reads 0 when `parity_en` is 0.
- R8: When `lo_first` is 0, `rd_lo` pops the head entry. When `lo_first` is 1, `rd_hi` pops it. The other read alone leaves the head entry in place, and a read of an empty FIFO changes nothing.
- R9: When `lin_auto` is 1, status bit 0 reads 0 for a character tagged as an identifier and 1 for a response character. Otherwise bit 0 is the ninth data bit.
- R10: When `spi_master` is 1, status bits 6, 2 and 1 read 0.
- R11: While the FIFO is full, a character in the hold stage stays there until a slot frees. A push and a pop in the same cycle both complete, and the FIFO stays full.
- R12: `data_lo` shows the head character's eight data bits, and 0x00 when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; low flushes all state |
| lo_first | input | 1 | 9-bit low-byte-first read order |
| parity_en | input | 1 | Parity checking enabled |
| lin_auto | input | 1 | LIN auto mode: bit 0 becomes the response tag |
| spi_master | input | 1 | SPI master mode: error flags forced to 0 |
| in_valid | input | 1 | One-cycle strobe: a finished character is offered |
| in_data | input | 8 | Data bits of the offered character |
| in_bit8 | input | 1 | Ninth data bit |
| in_stop1 | input | 1 | Value of the first stop bit |
| in_par_err | input | 1 | Parity check failed |
| in_is_id | input | 1 | Character is a LIN protected identifier |
| start_det | input | 1 | Shift stage detected a new start bit |
| rd_lo | input | 1 | Data byte read strobe |
| rd_hi | input | 1 | Status byte read strobe |
| data_lo | output | 8 | Head character data byte |
| status_hi | output | 8 | Status byte of the head character |

## Verification
The assertions check on every cycle that the status byte never shows an error flag in SPI-master mode and that bit 1 stays 0 with parity off. They also check that a flush empties the buffer by the next cycle, that a new overflow flag always follows a full FIFO with a waiting character and a start bit, and that the hold stage keeps its character while the FIFO is blocked. Only the bench scenarios can show the following: characters come out in order, which character is discarded on overflow, how the two read orders behave, that the flags follow the head entry across pops, and that mode changes act on characters already stored. The bench covers these with directed sequences and with a long random stream checked against a queue model.

// File: rtl/rxb_pkg.sv
// Shared types for the serial receive character buffer.
package rxb_pkg;

    localparam int BYTE_W = 8;

    // One buffered character with the status that travels with it.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bit8;
        logic              ferr;
        logic              perr;
        logic              is_id;
    } rx_entry_t;

endpackage

// File: rtl/rxb_hold.sv
// Hold stage between the receive shift stage and the FIFO.
// Captures a finished character and forwards it when the FIFO has room
// (a same-cycle pop counts as room). If the FIFO is full, the character
// waits here. When a start bit is seen while the character waits, this
// stage reports an overflow and discards the waiting character.
// Assumes the shift stage offers no new character while one is waiting,
// unless an overflow has cleared the slot first.
module rxb_hold
    import rxb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      in_valid,
    input  rx_entry_t in_entry,
    input  logic      start_det,
    input  logic      fifo_full,
    input  logic      fifo_pop,
    output logic      hold_valid,
    output rx_entry_t hold_entry,
    output logic      push,
    output logic      ovf_evt
);

    logic      valid_q;
    rx_entry_t entry_q;

    // Forward when a slot is free or frees up in this cycle.
    always_comb begin
        push    = valid_q && (!fifo_full || fifo_pop);
        ovf_evt = valid_q && fifo_full && !fifo_pop && start_det;
    end

    // Hold register: load, keep, or drop.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            valid_q <= 1'b0;
            entry_q <= '0;
        end else if (in_valid) begin
            valid_q <= 1'b1;
            entry_q <= in_entry;
        end else if (push || ovf_evt) begin
            valid_q <= 1'b0;
        end
    end

    assign hold_valid = valid_q;
    assign hold_entry = entry_q;

    AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && valid_q && fifo_full && !fifo_pop && !start_det && !in_valid)
        |=> (valid_q && $stable(entry_q))) // R11
        else $error("hold stage lost a waiting character");

endmodule

// File: rtl/rxb_fifo.sv
// Circular FIFO of buffered characters with a combinational head output.
// A push and a pop in the same cycle are both carried out, including when
// the FIFO is full. Assumes push is raised only when a slot is free or a
// pop happens in the same cycle.
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write for each slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (push && wr_ptr == PTR_W'(g)) begin
                mem[g] <= push_entry;
            end
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)) // R11
        else $error("push into a full FIFO without a pop");

    AST_FULL_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && full && push && pop) |=> full) // R11
        else $error("simultaneous push and pop lost an entry");

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) // R8
        else $error("pop from an empty FIFO");

endmodule

// File: rtl/rxb_status.sv
// Builds the two read bytes from the head entry and the current modes.
// Bit 0 is the response tag in LIN auto mode and the ninth data bit
// otherwise. The error flags are masked in SPI master mode, and parity
// is also masked when checking is off. Purely combinational.
module rxb_status
    import rxb_pkg::*;
(
    input  rx_entry_t         head,
    input  logic              nonempty,
    input  logic              ovf,
    input  logic              spi_master,
    input  logic              parity_en,
    input  logic              lin_auto,
    output logic [BYTE_W-1:0] data_byte,
    output logic [BYTE_W-1:0] status_byte
);

    // Format the read bytes; an empty FIFO reads as zero.
    always_comb begin
        status_byte    = '0;
        data_byte      = nonempty ? head.data : '0;
        status_byte[7] = nonempty;
        status_byte[6] = ovf && !spi_master;
        status_byte[2] = nonempty && head.ferr && !spi_master;
        status_byte[1] = nonempty && head.perr && parity_en && !spi_master;
        status_byte[0] = nonempty && (lin_auto ? !head.is_id : head.bit8);
    end

endmodule

// File: rtl/rx_char_buffer.sv
// Receive character buffer: a hold stage, a character FIFO, the overflow
// flag and the read-order pop logic. The pop happens on the second read
// of a pair: the data-byte read normally, and the status-byte read in the
// low-byte-first mode. The overflow flag is cleared by a data-byte read.
// Assumes rd_lo and rd_hi are one-cycle strobes from the register bus.
module rx_char_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_enable,
    input  logic        lo_first,
    input  logic        parity_en,
    input  logic        lin_auto,
    input  logic        spi_master,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_bit8,
    input  logic        in_stop1,
    input  logic        in_par_err,
    input  logic        in_is_id,
    input  logic        start_det,
    input  logic        rd_lo,
    input  logic        rd_hi,
    output logic [7:0]  data_lo,
    output logic [7:0]  status_hi
);

    rx_entry_t        in_entry, hold_entry, head;
    logic             hold_valid, push, ovf_evt, pop;
    logic             full, empty, ovf_q;
    logic [CNT_W-1:0] fifo_cnt;

    // Pack the incoming character; the stop bit becomes a frame-error flag.
    always_comb begin
        in_entry.data  = in_data;
        in_entry.bit8  = in_bit8;
        in_entry.ferr  = !in_stop1;
        in_entry.perr  = in_par_err;
        in_entry.is_id = in_is_id;
    end

    // The second read of the pair pops a non-empty FIFO.
    assign pop = (lo_first ? rd_hi : rd_lo) && !empty;

    rxb_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_enable),
        .in_valid   (in_valid),
        .in_entry   (in_entry),
        .start_det  (start_det),
        .fifo_full  (full),
        .fifo_pop   (pop),
        .hold_valid (hold_valid),
        .hold_entry (hold_entry),
        .push       (push),
        .ovf_evt    (ovf_evt)
    );

    rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (!rx_enable),
        .push       (push),
        .push_entry (hold_entry),
        .pop        (pop),
        .head       (head),
        .count      (fifo_cnt),
        .full       (full),
        .empty      (empty)
    );

    // Sticky overflow: a new event wins over the data-byte read clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_enable) begin
            ovf_q <= 1'b0;
        end else if (ovf_evt) begin
            ovf_q <= 1'b1;
        end else if (rd_lo) begin
            ovf_q <= 1'b0;
        end
    end

    rxb_status u_status (
        .head        (head),
        .nonempty    (!empty),
        .ovf         (ovf_q),
        .spi_master  (spi_master),
        .parity_en   (parity_en),
        .lin_auto    (lin_auto),
        .data_byte   (data_lo),
        .status_byte (status_hi)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (status_hi[7] == 1'b0)) // R4
        else $error("receiver disable did not flush");

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_master && !$past(spi_master) && $rose(status_hi[6]))
        |-> ($past(fifo_cnt) == CNT_W'(DEPTH) && $past(hold_valid) && $past(start_det))) // R5
        else $error("overflow flagged without its three conditions");

    AST_SPI_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        spi_master |-> (status_hi[6] == 1'b0 && status_hi[2:1] == 2'b00)) // R10
        else $error("error flag visible in SPI master mode");

    AST_PARITY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_en |-> (status_hi[1] == 1'b0)) // R7
        else $error("parity flag visible with checking off");

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_hi[5:3] == 3'b000) // R2
        else $error("reserved status bits not zero");

endmodule

// File: tb/tb_rx_char_buffer.sv
module tb_rx_char_buffer;

    typedef struct {
        logic [7:0] d;
        logic b8, stop1, pe, id;
    } ch_t;

    logic clk = 0;
    logic rst_n = 0;
    logic rx_enable = 1, lo_first = 0, parity_en = 1, lin_auto = 0, spi_master = 0;
    logic in_valid = 0, in_bit8 = 0, in_stop1 = 1, in_par_err = 0, in_is_id = 0;
    logic [7:0] in_data = 0;
    logic start_det = 0, rd_lo = 0, rd_hi = 0;
    logic [7:0] data_lo, status_hi;

    int checks = 0, errors = 0, cycles = 0;

    // Reference model state
    ch_t m_q[$];
    ch_t m_hold;
    bit  m_hold_v = 0;
    bit  m_ovf = 0;

    always #5 clk = ~clk;

    rx_char_buffer dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .lo_first(lo_first),
        .parity_en(parity_en), .lin_auto(lin_auto), .spi_master(spi_master),
        .in_valid(in_valid), .in_data(in_data), .in_bit8(in_bit8),
        .in_stop1(in_stop1), .in_par_err(in_par_err), .in_is_id(in_is_id),
        .start_det(start_det), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .data_lo(data_lo), .status_hi(status_hi)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Compare every output field against the model.
    task automatic compare();
        logic [7:0] ed, es;
        bit ne;
        ne = (m_q.size() != 0);
        ed = ne ? m_q[0].d : 8'h00;
        es = 8'h00;
        es[7] = ne;
        es[6] = m_ovf && !spi_master;
        es[2] = ne && !m_q[0].stop1 && !spi_master;
        es[1] = ne && m_q[0].pe && parity_en && !spi_master;
        es[0] = ne && (lin_auto ? !m_q[0].id : m_q[0].b8);
        chk(data_lo === ed, "R12 data byte", data_lo, ed);
        chk(status_hi[7] === es[7], "R3 receive complete", status_hi[7], es[7]);
        chk(status_hi[6] === es[6], "R5 overflow", status_hi[6], es[6]);
        chk(status_hi[2] === es[2], "R6 frame error", status_hi[2], es[2]);
        chk(status_hi[1] === es[1], "R7 parity error", status_hi[1], es[1]);
        chk(status_hi[0] === es[0], "R9 bit 0", status_hi[0], es[0]);
        chk(status_hi[5:3] === 3'b000, "R2 reserved bits", status_hi[5:3], 0);
    endtask

    // One clock: drive at negedge, advance the model, compare at next negedge.
    task automatic step(input bit iv = 0, input logic [7:0] d = 0, input bit b8 = 0,
                        input bit st = 1, input bit pe = 0, input bit id = 0,
                        input bit sd = 0, input bit rl = 0, input bit rh = 0);
        bit pop, full, acc, oe;
        in_valid = iv; in_data = d; in_bit8 = b8; in_stop1 = st;
        in_par_err = pe; in_is_id = id; start_det = sd; rd_lo = rl; rd_hi = rh;
        @(posedge clk);
        if (!rst_n || !rx_enable) begin
            m_q.delete(); m_hold_v = 0; m_ovf = 0;
        end else begin
            pop  = (lo_first ? rh : rl) && (m_q.size() != 0);
            full = (m_q.size() == 2);
            acc  = m_hold_v && (!full || pop);
            oe   = m_hold_v && full && !pop && sd;
            if (pop) void'(m_q.pop_front());
            if (acc) m_q.push_back(m_hold);
            if (oe) m_ovf = 1; else if (rl) m_ovf = 0;
            if (iv) begin
                m_hold_v = 1;
                m_hold = '{d: d, b8: b8, stop1: st, pe: pe, id: id};
            end else if (acc || oe) m_hold_v = 0;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic send(input logic [7:0] d, input bit b8 = 0, input bit st = 1,
                        input bit pe = 0, input bit id = 0);
        step(1, d, b8, st, pe, id);
        step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        chk(status_hi === 8'h00, "R2 reset status", status_hi, 8'h00);
        chk(data_lo === 8'h00, "R12 reset data", data_lo, 8'h00);
        rst_n = 1;
        step();

        // R1/R8: one character, normal order; status read alone keeps it
        send(8'hA5, 1);
        chk(status_hi === 8'h81, "R1 status after arrival", status_hi, 8'h81);
        step(.rh(1));
        chk(data_lo === 8'hA5, "R8 status read keeps head", data_lo, 8'hA5);
        step(.rl(1));
        chk(status_hi === 8'h00, "R8 data read pops", status_hi, 8'h00);
        step(.rl(1));
        chk(status_hi === 8'h00, "R8 read of empty ignored", status_hi, 8'h00);

        // R5: overflow only with full FIFO, waiting character and start bit
        send(8'h11); send(8'h22); send(8'h33);
        chk(status_hi[6] === 1'b0, "R5 no overflow without start", status_hi[6], 0);
        step(.sd(1));
        chk(status_hi === 8'hC0, "R5 overflow set", status_hi, 8'hC0);
        step(.rl(1));
        chk(data_lo === 8'h22 && status_hi === 8'h80, "R5 cleared by data read",
            {data_lo, status_hi}, 16'h2280);
        step(.rl(1));
        chk(status_hi === 8'h00, "R5 waiting character discarded", status_hi, 8'h00);

        // R11: full FIFO, waiting character, push and pop together
        send(8'h41); send(8'h42); send(8'h43);
        step(.rl(1));
        chk(data_lo === 8'h42, "R11 pop with push keeps order", data_lo, 8'h42);
        step(.rl(1));
        chk(data_lo === 8'h43, "R11 waiting character kept", data_lo, 8'h43);
        step(.rl(1));

        // R8: low-byte-first order
        lo_first = 1;
        send(8'h3C, 1);
        step(.rl(1));
        chk(status_hi === 8'h81, "R8 low-first data read keeps head", status_hi, 8'h81);
        step(.rh(1));
        chk(status_hi === 8'h00, "R8 low-first status read pops", status_hi, 8'h00);
        lo_first = 0;

        // R6/R7: frame error and parity masking
        send(8'h5A, 0, 0, 1);
        chk(status_hi === 8'h86, "R6 frame and parity error", status_hi, 8'h86);
        parity_en = 0; step();
        chk(status_hi === 8'h84, "R7 parity masked when off", status_hi, 8'h84);
        parity_en = 1;
        // R10: SPI master masks errors
        spi_master = 1; step();
        chk(status_hi === 8'h80, "R10 SPI master masks errors", status_hi, 8'h80);
        spi_master = 0;
        step(.rl(1));

        // R9: LIN identifier and response tagging
        lin_auto = 1;
        send(8'h80, 1, 1, 0, 1);
        chk(status_hi === 8'h80, "R9 identifier bit 0 low", status_hi, 8'h80);
        step(.rl(1));
        send(8'h07, 0, 1, 0, 0);
        chk(status_hi === 8'h81, "R9 response bit 0 high", status_hi, 8'h81);
        step(.rl(1));
        lin_auto = 0;

        // R4: disable flushes and ignores input
        send(8'h01); send(8'h02); send(8'h03); step(.sd(1));
        rx_enable = 0;
        step(1, 8'h77);
        chk(status_hi === 8'h00, "R4 flush on disable", status_hi, 8'h00);
        step();
        rx_enable = 1;
        step(); step();
        chk(status_hi === 8'h00, "R4 input ignored while disabled", status_hi, 8'h00);

        // Random stream against the model
        for (int i = 0; i < 3000; i++) begin
            bit iv;
            if (i % 500 == 0) begin
                lo_first   = $urandom_range(0, 1);
                parity_en  = $urandom_range(0, 1);
                lin_auto   = $urandom_range(0, 1);
                spi_master = ($urandom_range(0, 3) == 0);
                rx_enable  = ($urandom_range(0, 7) != 0);
            end
            iv = !m_hold_v && ($urandom_range(0, 2) == 0);
            step(iv, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule